// File: doc/BRIEF.md
# Signed Multiply-Accumulate Coprocessor Unit

This unit sits beside a 16-bit processor as a small arithmetic coprocessor. It holds a 32-bit accumulator and an 8-bit mode register. The processor loads the mode through a mode-write strobe. It then issues operations through an operate strobe, which carries two 16-bit signed arguments.

In the two accumulate modes, each operation adds the signed product of the arguments to the accumulator. One half of the new accumulator value is returned. In the read-back mode, the upper half of the accumulator is returned and nothing is computed. Every result comes with a 4-bit flag vector in C,V,Z,N order, where only V is ever set. V reports signed overflow of the accumulation. V is sticky across read-back operations, so software can test for overflow after a chain of accumulations.

Top module: `smac_unit`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the mode register (to 0x00), the overflow flag and the result output.
- R2: An accumulate operation sets the accumulator to the old value plus the signed 16x16 product, wrapping modulo 2^32.
- R3: In mode 0x07 an operation accumulates and returns bits 15:0 of the new accumulator.
- R4: In mode 0x17 an operation accumulates and returns bits 31:16 of the new accumulator.
- R5: In mode 0x13 an operation does no arithmetic, leaves the accumulator unchanged and returns its bits 31:16.
- R6: Overflow is detected when the product and the old accumulator are both non-negative and the new sum is negative, or when both are negative and the sum is non-negative. The flag vector is then 0b0100 (bit 3 C, bit 2 V, bit 1 Z, bit 0 N).
- R7: An accumulate operation without overflow clears V, so the flag vector reads 0b0000.
- R8: A read-back operation in mode 0x13 leaves V unchanged.
- R9: An operation in any other mode clears V, returns zero and leaves the accumulator unchanged.
- R10: The result and flags change only on the clock edge that samples the operate strobe, so they are valid one cycle later, and they hold while no operation is issued.
- R11: A mode write changes neither the accumulator, the result output nor the flags. An operation issued in the same cycle as a mode write uses the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_we | input | 1 | Mode register write strobe |
| mode_in | input | 8 | Mode code to load |
| op_go | input | 1 | Operate strobe |
| op_a | input | 16 | First signed argument |
| op_b | input | 16 | Second signed argument |
| res_out | output | 16 | Selected result half |
| flags_out | output | 4 | Flags C,V,Z,N (bit 3 down to bit 0) |

## Verification
The bench sweeps every pair of an edge-value set that includes 0, ±1, 0x7FFF and 0x8000. It runs this sweep in both accumulate modes while a model computes the sums, so a design that truncates or zero-extends the product, or returns the wrong half, shows up at once. Directed sequences drive the accumulator across the positive and negative limits. These catch a wrong sign rule, which either misses a wrap or flags a legal sum. Further sequences then issue read-backs, no-overflow accumulations and unknown-mode operations. They expose a V flag that is cleared by a read-back, or that stays set when it should clear. Checks also sample the outputs in the strobe cycle and after idle cycles and mode writes. These catch a combinational output path and a mode write that disturbs state.

// File: rtl/smac_pkg.sv
package smac_pkg;
   localparam logic [7:0] MODE_MAC_LO = 8'h07;
   localparam logic [7:0] MODE_MAC_HI = 8'h17;
   localparam logic [7:0] MODE_RD_HI  = 8'h13;
   localparam int         FLAG_W      = 4;
   localparam int         FLAG_V_BIT  = 2;

   typedef enum logic [1:0] {
      OPK_OTHER  = 2'd0,
      OPK_MAC_LO = 2'd1,
      OPK_MAC_HI = 2'd2,
      OPK_RD_HI  = 2'd3
   } op_kind_e;
endpackage

// File: rtl/smac_decode.sv
module smac_decode
   import smac_pkg::*;
#(
   parameter int MODE_W = 8
) (
   input  logic [MODE_W-1:0] mode,
   output op_kind_e          kind
);
   if (MODE_W != 8) begin : g_bad_mode_w
      $error("smac_decode: MODE_W must be 8");
   end

   always_comb begin
      unique case (mode)
         MODE_MAC_LO: kind = OPK_MAC_LO;
         MODE_MAC_HI: kind = OPK_MAC_HI;
         MODE_RD_HI:  kind = OPK_RD_HI;
         default:     kind = OPK_OTHER;
      endcase
   end
endmodule

// File: rtl/smac_macc.sv
module smac_macc #(
   parameter int ARG_W = 16,
   parameter int ACC_W = 32
) (
   input  logic signed [ARG_W-1:0] arg_a,
   input  logic signed [ARG_W-1:0] arg_b,
   input  logic        [ACC_W-1:0] acc_old,
   output logic        [ACC_W-1:0] acc_new,
   output logic                    ovf
);
   localparam int MSB = ACC_W - 1;

   if (ACC_W != 2 * ARG_W) begin : g_bad_acc_w
      $error("smac_macc: ACC_W must equal 2*ARG_W");
   end

   logic signed [ACC_W-1:0] prod;
   logic                    s_prod, s_old, s_new;

   assign prod    = arg_a * arg_b;
   assign acc_new = acc_old + prod;
   assign s_prod  = prod[MSB];
   assign s_old   = acc_old[MSB];
   assign s_new   = acc_new[MSB];
   assign ovf     = (~s_prod & ~s_old & s_new) | (s_prod & s_old & ~s_new);
endmodule

// File: rtl/smac_halfsel.sv
module smac_halfsel #(
   parameter int WORD_W = 32,
   parameter int OUT_W  = 16
) (
   input  logic [WORD_W-1:0] word,
   input  logic              sel_hi,
   output logic [OUT_W-1:0]  half
);
   localparam int NPART = WORD_W / OUT_W;

   if (NPART != 2 || WORD_W % OUT_W != 0) begin : g_bad_split
      $error("smac_halfsel: WORD_W must be twice OUT_W");
   end

   logic [OUT_W-1:0] part [NPART];

   for (genvar gi = 0; gi < NPART; gi++) begin : g_part
      assign part[gi] = word[gi*OUT_W +: OUT_W];
   end

   assign half = sel_hi ? part[NPART-1] : part[0];
endmodule

// File: rtl/smac_unit.sv
module smac_unit
   import smac_pkg::*;
#(
   parameter int ARG_W  = 16,
   parameter int MODE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mode_we,
   input  logic [MODE_W-1:0] mode_in,
   input  logic              op_go,
   input  logic [ARG_W-1:0]  op_a,
   input  logic [ARG_W-1:0]  op_b,
   output logic [ARG_W-1:0]  res_out,
   output logic [FLAG_W-1:0] flags_out
);
   localparam int ACC_W = 2 * ARG_W;

   logic [MODE_W-1:0] mode_q;
   logic [ACC_W-1:0]  acc_q;
   logic              ovf_q;
   logic [ARG_W-1:0]  out_q;

   op_kind_e          kind;
   logic [ACC_W-1:0]  acc_sum;
   logic              sum_ovf;
   logic [ACC_W-1:0]  sel_word;
   logic              sel_hi;
   logic [ARG_W-1:0]  sel_half;

   smac_decode #(.MODE_W(MODE_W)) u_dec (
      .mode (mode_q),
      .kind (kind)
   );

   smac_macc #(.ARG_W(ARG_W), .ACC_W(ACC_W)) u_macc (
      .arg_a   (op_a),
      .arg_b   (op_b),
      .acc_old (acc_q),
      .acc_new (acc_sum),
      .ovf     (sum_ovf)
   );

   assign sel_word = (kind == OPK_RD_HI) ? acc_q : acc_sum;
   assign sel_hi   = (kind != OPK_MAC_LO);

   smac_halfsel #(.WORD_W(ACC_W), .OUT_W(ARG_W)) u_sel (
      .word   (sel_word),
      .sel_hi (sel_hi),
      .half   (sel_half)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= '0;
         acc_q  <= '0;
         ovf_q  <= 1'b0;
         out_q  <= '0;
      end else begin
         if (mode_we) mode_q <= mode_in;
         if (op_go) begin
            unique case (kind)
               OPK_MAC_LO, OPK_MAC_HI: begin
                  acc_q <= acc_sum;
                  ovf_q <= sum_ovf;
                  out_q <= sel_half;
               end
               OPK_RD_HI: out_q <= sel_half;
               default: begin
                  ovf_q <= 1'b0;
                  out_q <= '0;
               end
            endcase
         end
      end
   end

   always_comb begin
      flags_out             = '0;
      flags_out[FLAG_V_BIT] = ovf_q;
   end
   assign res_out = out_q;
endmodule

// File: rtl/smac_unit_chk.sv
module smac_unit_chk
   import smac_pkg::*;
#(
   parameter int ARG_W  = 16,
   parameter int MODE_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              mode_we,
   input logic              op_go,
   input logic [MODE_W-1:0] mode_q,
   input logic [2*ARG_W-1:0] acc_q,
   input logic [ARG_W-1:0]  res_out,
   input logic [FLAG_W-1:0] flags_out
);
   // R1
   reset_clear_chk: assert property (@(posedge clk) rst |=> (res_out == '0 && flags_out == '0));

   // R6
   flag_shape_chk: assert property (@(posedge clk) disable iff (rst)
      (flags_out[3] == 1'b0 && flags_out[1:0] == 2'b00));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!op_go && !rst) |=> ($stable(res_out) && $stable(flags_out)));

   // R11
   mode_wr_acc_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_we && !op_go) |=> $stable(acc_q));

   // R8
   read_keeps_v_chk: assert property (@(posedge clk) disable iff (rst)
      (op_go && mode_q == MODE_RD_HI) |=> $stable(flags_out));

   // R5
   read_value_chk: assert property (@(posedge clk) disable iff (rst)
      (op_go && mode_q == MODE_RD_HI) |=> (res_out == $past(acc_q[2*ARG_W-1:ARG_W]) && $stable(acc_q)));

   // R9
   other_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (op_go && mode_q != MODE_RD_HI && mode_q != MODE_MAC_LO && mode_q != MODE_MAC_HI)
      |=> (flags_out == '0 && res_out == '0 && $stable(acc_q)));
endmodule

bind smac_unit smac_unit_chk #(.ARG_W(ARG_W), .MODE_W(MODE_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .mode_we   (mode_we),
   .op_go     (op_go),
   .mode_q    (mode_q),
   .acc_q     (acc_q),
   .res_out   (res_out),
   .flags_out (flags_out)
);

// File: tb/smac_unit_tb.sv
module smac_unit_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        mode_we = 1'b0;
   logic [7:0]  mode_in = '0;
   logic        op_go = 1'b0;
   logic [15:0] op_a = '0;
   logic [15:0] op_b = '0;
   logic [15:0] res_out;
   logic [3:0]  flags_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [31:0] acc_ref;
   logic        ovf_ref;

   always #(CLK_PERIOD/2) clk = ~clk;

   smac_unit u_dut (
      .clk(clk), .rst(rst), .mode_we(mode_we), .mode_in(mode_in),
      .op_go(op_go), .op_a(op_a), .op_b(op_b),
      .res_out(res_out), .flags_out(flags_out)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk) rst = 1'b1;
      @(negedge clk) rst = 1'b0;
      acc_ref = '0;
      ovf_ref = 1'b0;
   endtask

   task automatic set_mode(input logic [7:0] m);
      @(negedge clk) begin mode_we = 1'b1; mode_in = m; end
      @(negedge clk) mode_we = 1'b0;
   endtask

   task automatic issue(input logic [15:0] a, input logic [15:0] b);
      logic [15:0] old_res;
      logic [3:0]  old_flg;
      @(negedge clk) begin op_a = a; op_b = b; op_go = 1'b1; end
      old_res = res_out;
      old_flg = flags_out;
      #1;
      if (res_out !== old_res || flags_out !== old_flg)
         check("R10 output moved before edge", {res_out, flags_out, 12'h0}, {old_res, old_flg, 12'h0});
      @(negedge clk) op_go = 1'b0;
   endtask

   task automatic mac(input logic [15:0] a, input logic [15:0] b, input bit hi, input string tag);
      logic signed [31:0] p;
      logic [31:0] s;
      p = $signed(a) * $signed(b);
      s = acc_ref + p;
      ovf_ref = (~p[31] & ~acc_ref[31] & s[31]) | (p[31] & acc_ref[31] & ~s[31]);
      acc_ref = s;
      issue(a, b);
      check({tag, hi ? " R4 R2 high half" : " R3 R2 low half"}, {16'h0, res_out},
            {16'h0, hi ? acc_ref[31:16] : acc_ref[15:0]});
      check({tag, " R6 R7 flags"}, {28'h0, flags_out}, {28'h0, ovf_ref ? 4'b0100 : 4'b0000});
   endtask

   task automatic readback(input string tag);
      issue(16'h1234, 16'h5678);
      check({tag, " R5 read value"}, {16'h0, res_out}, {16'h0, acc_ref[31:16]});
      check({tag, " R8 read keeps V"}, {28'h0, flags_out}, {28'h0, ovf_ref ? 4'b0100 : 4'b0000});
   endtask

   function automatic logic [15:0] edge_val(input int i);
      case (i)
         0: return 16'h0000;
         1: return 16'h0001;
         2: return 16'hFFFF;
         3: return 16'h7FFF;
         4: return 16'h8000;
         5: return 16'h0002;
         6: return 16'hFFFE;
         default: return 16'h1234;
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      acc_ref = '0;
      ovf_ref = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      check("R1 reset result", {16'h0, res_out}, 32'h0);
      check("R1 reset flags", {28'h0, flags_out}, 32'h0);
      set_mode(8'h13);
      readback("R1 accumulator cleared");

      // sweeps in both accumulate modes
      set_mode(8'h07);
      for (int i = 0; i < 8; i++)
         for (int j = 0; j < 8; j++)
            mac(edge_val(i), edge_val(j), 1'b0, "sweep lo");
      set_mode(8'h17);
      for (int i = 0; i < 8; i++)
         for (int j = 0; j < 8; j++)
            mac(edge_val(j), edge_val(i), 1'b1, "sweep hi");
      set_mode(8'h13);
      readback("after sweep");
      readback("after sweep again");

      // positive overflow then sticky, then clear
      do_reset();
      set_mode(8'h07);
      mac(16'h7FFF, 16'h7FFF, 1'b0, "pos 1");
      mac(16'h7FFF, 16'h7FFF, 1'b0, "pos 2");
      mac(16'h7FFF, 16'h7FFF, 1'b0, "pos ovf");
      check("R6 overflow seen", {31'h0, ovf_ref}, 32'h1);
      set_mode(8'h13);
      readback("R8 sticky 1");
      readback("R8 sticky 2");
      set_mode(8'h17);
      mac(16'h0000, 16'h0000, 1'b1, "R7 zero clears");
      // negative overflow
      mac(16'h7FFF, 16'h7FFF, 1'b1, "neg prep");
      mac(16'h8000, 16'h7FFF, 1'b1, "neg a");
      mac(16'h8000, 16'h7FFF, 1'b1, "neg b");
      mac(16'h8000, 16'h7FFF, 1'b1, "neg c");
      mac(16'h8000, 16'h7FFF, 1'b1, "neg d");
      mac(16'h8000, 16'h8000, 1'b1, "neg e");

      // force a known set V then other mode clears
      do_reset();
      set_mode(8'h07);
      mac(16'h7FFF, 16'h7FFF, 1'b0, "o1");
      mac(16'h7FFF, 16'h7FFF, 1'b0, "o2");
      mac(16'h7FFF, 16'h7FFF, 1'b0, "o3");
      set_mode(8'h00);
      issue(16'h0100, 16'h0100);
      ovf_ref = 1'b0;
      check("R9 other mode flags", {28'h0, flags_out}, 32'h0);
      check("R9 other mode result", {16'h0, res_out}, 32'h0);
      set_mode(8'h13);
      readback("R9 acc unchanged");

      // R10 hold and R11 mode write
      set_mode(8'h07);
      mac(16'h0003, 16'hFFFB, 1'b0, "hold prep");
      repeat (3) @(negedge clk);
      check("R10 hold result", {16'h0, res_out}, {16'h0, acc_ref[15:0]});
      check("R10 hold flags", {28'h0, flags_out}, {28'h0, ovf_ref ? 4'b0100 : 4'b0000});
      set_mode(8'h17);
      check("R11 mode write result", {16'h0, res_out}, {16'h0, acc_ref[15:0]});
      check("R11 mode write flags", {28'h0, flags_out}, {28'h0, ovf_ref ? 4'b0100 : 4'b0000});
      // same-cycle write uses old mode (0x17)
      @(negedge clk) begin
         mode_we = 1'b1; mode_in = 8'h13; op_a = 16'h0010; op_b = 16'h1000; op_go = 1'b1;
      end
      @(negedge clk) begin mode_we = 1'b0; op_go = 1'b0; end
      acc_ref = acc_ref + 32'h0001_0000;
      check("R11 same-cycle old mode", {16'h0, res_out}, {16'h0, acc_ref[31:16]});
      readback("R11 new mode active");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule